// File: doc/BRIEF.md
# Two-Candidate Bivariate Interpolation Engine

This block builds a bivariate polynomial Q(x,y) = q0(x) + y·q1(x) over GF(2^M) that passes through a stream of points, each taken with multiplicity one. It keeps two candidate polynomials at all times. For every new point it works out the value of each candidate at that point, called the discrepancy. It then picks a pivot and updates every coefficient of both candidates. When the last point has been applied, it streams out the candidate with the smaller weighted degree.

Coefficients are held in small register-file memories, one fixed slot per candidate and per y-degree. One pass over the coefficients, from the highest x-degree down to zero, updates them with the discrepancies of the previous point. In the same pass, a Horner evaluator for each candidate takes every freshly updated coefficient and evaluates the new polynomial at the next point. As a result, the update for one point and the evaluation for the next point share the same cycles. Every discrepancy pair is also sent out on its own port, so that a neighbouring evaluation-update unit can use it.

A run is opened with a start strobe. Points then arrive over a valid/ready handshake, and the last point of the run is flagged.

Top module: `biv_interp`

## Requirements
- R1: Out of reset and in idle, pt_ready_o, disc_valid_o, res_valid_o and done_o are low. A start_i pulse in idle sets candidate 0 to 1 and candidate 1 to y, with weighted degrees 0 and WY. It raises pt_ready_o in the following cycle.
- R2: One point is accepted per iteration. Acceptance happens on an edge where pt_valid_i and pt_ready_o are both high. pt_ready_o is low in the cycle after acceptance, and it stays low until that point's discrepancies have been exported.
- R3: For each accepted point (x,y), in order, disc_valid_o pulses for exactly one cycle. disck_o then carries qk0(x) XOR y·qk1(x) for candidate k, computed after all earlier points have been applied.
- R4: The pulse of R3 comes S+2 clock edges after the accepting edge, where S = 1 + (number of points, other than the immediately preceding one, whose discrepancy pair was not all zero).
- R5: The pivot is chosen among the candidates with a nonzero discrepancy, taking the lower weighted degree. When both qualify and their weighted degrees are equal, candidate 0 is the pivot. The other candidate becomes d_pivot·Q_other + d_other·Q_pivot. The pivot becomes (x + x_i)·Q_pivot, and its weighted degree rises by one.
- R6: When both discrepancies of a point are zero, neither candidate and neither weighted degree changes. A repeated point therefore has no effect on the result.
- R7: Weighted degree counts weight 1 for x and WY for y. The output candidate is the one with the smaller weighted degree, with candidate 0 chosen on a tie. Weighted degrees never decrease during a run.
- R8: After the final point, res_valid_o is high for S_f consecutive cycles, where S_f = 1 + the number of points with a nonzero discrepancy pair. In each of these cycles, res_idx_o gives the x-degree, from S_f-1 down to 0. res_c0_o is the coefficient of x^idx·y^0 and res_c1_o is the coefficient of x^idx·y^1. All higher coefficients are zero. done_o is high together with index 0.
- R9: The output polynomial evaluates to zero at every point of the run.
- R10: Field elements are M-bit vectors, with bit i the coefficient of alpha^i. Multiplication reduces modulo x^M + POLY, where POLY holds the lower M bits. A run carries at most NPTS_MAX points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a run (only acted on in idle) |
| pt_valid_i | input | 1 | Point offered |
| pt_ready_o | output | 1 | Engine can accept a point |
| pt_x_i | input | M | Point x coordinate |
| pt_y_i | input | M | Point y coordinate |
| pt_last_i | input | 1 | Final point of the run |
| disc_valid_o | output | 1 | Discrepancy pair valid |
| disc0_o | output | M | Discrepancy of candidate 0 |
| disc1_o | output | M | Discrepancy of candidate 1 |
| res_valid_o | output | 1 | Result coefficient valid |
| res_idx_o | output | AW | x-degree of the result coefficient |
| res_c0_o | output | M | y^0 coefficient at that x-degree |
| res_c1_o | output | M | y^1 coefficient at that x-degree |
| done_o | output | 1 | Last result coefficient |

## Verification
The hardest situations to reach are the two corner cases of the pivot rule. The first is the case in which both discrepancies are zero. Random points from a wide field almost never produce it. The bench reaches it on purpose by offering a point that is already on the curve, or a point offered twice. The second is the tie in weighted degree. It appears only once candidate 0 has grown to WY, so runs of the full NPTS_MAX length are used to drive the counters through it. The bench checks every discrepancy pair, its arrival cycle and the final coefficients against a bench-side model of the same recursion. It also evaluates the output at every point of the run.

// File: rtl/interp2_pkg.sv
package interp2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PASS,
    ST_FIN,
    ST_OUT
  } state_e;
endpackage

// File: rtl/gf_mult.sv
module gf_mult #(
  parameter int unsigned M = 8,
  parameter logic [M-1:0] POLY = 'h1D
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] p_o
);
  logic [M-1:0] acc, sh;
  always_comb begin
    acc = '0;
    sh  = a_i;
    for (int i = 0; i < M; i++) begin
      if (b_i[i]) acc = acc ^ sh;
      sh = {sh[M-2:0], 1'b0} ^ (sh[M-1] ? POLY : '0);
    end
    p_o = acc;
  end
endmodule

// File: rtl/coef_update.sv
// one y-degree, both candidates, one x-degree per cycle
module coef_update #(
  parameter int unsigned M = 8,
  parameter logic [M-1:0] POLY = 'h1D
) (
  input  logic         en_i,
  input  logic         piv_i,
  input  logic [M-1:0] dpiv_i,
  input  logic [M-1:0] doth_i,
  input  logic [M-1:0] xi_i,
  input  logic [M-1:0] c0_i,
  input  logic [M-1:0] c0l_i,
  input  logic [M-1:0] c1_i,
  input  logic [M-1:0] c1l_i,
  output logic [M-1:0] n0_o,
  output logic [M-1:0] n1_o
);
  logic [M-1:0] pc, pl, oc, xpc, t_a, t_b, new_p, new_o;

  assign pc = piv_i ? c1_i  : c0_i;
  assign pl = piv_i ? c1l_i : c0l_i;
  assign oc = piv_i ? c0_i  : c1_i;

  gf_mult #(.M(M), .POLY(POLY)) u_xs (.a_i(xi_i),   .b_i(pc), .p_o(xpc));
  gf_mult #(.M(M), .POLY(POLY)) u_ma (.a_i(dpiv_i), .b_i(oc), .p_o(t_a));
  gf_mult #(.M(M), .POLY(POLY)) u_mb (.a_i(doth_i), .b_i(pc), .p_o(t_b));

  assign new_p = pl ^ xpc;    // (x + xi) * pivot
  assign new_o = t_a ^ t_b;   // dp*other + do*pivot

  // results land in the fixed slot of each candidate, whichever is pivot
  assign n0_o = !en_i ? c0_i : (piv_i ? new_o : new_p);
  assign n1_o = !en_i ? c1_i : (piv_i ? new_p : new_o);
endmodule

// File: rtl/horner_eval.sv
module horner_eval #(
  parameter int unsigned M = 8,
  parameter logic [M-1:0] POLY = 'h1D
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [M-1:0] x_i,
  input  logic [M-1:0] y_i,
  input  logic [M-1:0] a0_i,
  input  logic [M-1:0] a1_i,
  output logic [M-1:0] disc_o
);
  logic [M-1:0] acc0_q, acc1_q, ax0, ax1, ya;

  gf_mult #(.M(M), .POLY(POLY)) u_h0 (.a_i(acc0_q), .b_i(x_i), .p_o(ax0));
  gf_mult #(.M(M), .POLY(POLY)) u_h1 (.a_i(acc1_q), .b_i(x_i), .p_o(ax1));
  gf_mult #(.M(M), .POLY(POLY)) u_y  (.a_i(y_i),    .b_i(acc1_q), .p_o(ya));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc0_q <= '0;
      acc1_q <= '0;
    end else if (clr_i) begin
      acc0_q <= '0;
      acc1_q <= '0;
    end else if (step_i) begin
      acc0_q <= ax0 ^ a0_i;
      acc1_q <= ax1 ^ a1_i;
    end
  end

  assign disc_o = acc0_q ^ ya;
endmodule

// File: rtl/biv_interp.sv
module biv_interp
  import interp2_pkg::*;
#(
  parameter int unsigned M        = 8,
  parameter logic [M-1:0] POLY    = 'h1D,
  parameter int unsigned WY       = 4,
  parameter int unsigned NPTS_MAX = 12,
  localparam int unsigned AW      = $clog2(NPTS_MAX + 1),
  localparam int unsigned DEPTH   = 2 ** AW,
  localparam int unsigned WDW     = $clog2(WY + NPTS_MAX + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          pt_valid_i,
  output logic          pt_ready_o,
  input  logic [M-1:0]  pt_x_i,
  input  logic [M-1:0]  pt_y_i,
  input  logic          pt_last_i,
  output logic          disc_valid_o,
  output logic [M-1:0]  disc0_o,
  output logic [M-1:0]  disc1_o,
  output logic          res_valid_o,
  output logic [AW-1:0] res_idx_o,
  output logic [M-1:0]  res_c0_o,
  output logic [M-1:0]  res_c1_o,
  output logic          done_o
);
  state_e            state_q;
  logic [M-1:0]      mem_q [2][2][DEPTH];   // [candidate][y-degree][x-degree]
  logic [AW-1:0]     cnt_q, cnt_lo;
  logic [AW:0]       span_q, span_n;
  logic [WDW-1:0]    wdeg0_q, wdeg1_q, wdeg0_n, wdeg1_n;
  logic [1:0][M-1:0] d_q, hd;
  logic              have_d_q, eval_q, sel_q;
  logic [M-1:0]      cur_x_q, nxt_x_q, nxt_y_q;
  logic              nxt_last_q;
  logic              nz0, nz1, upd_any, piv;
  logic [M-1:0]      dpiv, doth;
  logic [1:0][1:0][M-1:0] upd_n;
  logic              acc_clr, acc_step, in_pass;

  assign nz0     = |d_q[0];
  assign nz1     = |d_q[1];
  assign upd_any = have_d_q & (nz0 | nz1);
  assign piv     = (nz0 & nz1) ? (wdeg1_q < wdeg0_q) : nz1;
  assign dpiv    = piv ? d_q[1] : d_q[0];
  assign doth    = piv ? d_q[0] : d_q[1];
  assign wdeg0_n = wdeg0_q + WDW'(upd_any & ~piv);
  assign wdeg1_n = wdeg1_q + WDW'(upd_any & piv);
  assign span_n  = span_q + (AW+1)'(upd_any);
  assign cnt_lo  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
  assign in_pass = (state_q == ST_PASS);
  assign acc_clr  = (state_q == ST_WAIT) && pt_valid_i;
  assign acc_step = in_pass && eval_q;
  assign pt_ready_o = (state_q == ST_WAIT);

  for (genvar t = 0; t < 2; t++) begin : g_ydeg
    logic [M-1:0] lo0, lo1;
    assign lo0 = (cnt_q == '0) ? '0 : mem_q[0][t][cnt_lo];
    assign lo1 = (cnt_q == '0) ? '0 : mem_q[1][t][cnt_lo];
    coef_update #(.M(M), .POLY(POLY)) u_upd (
      .en_i  (upd_any),
      .piv_i (piv),
      .dpiv_i(dpiv),
      .doth_i(doth),
      .xi_i  (cur_x_q),
      .c0_i  (mem_q[0][t][cnt_q]),
      .c0l_i (lo0),
      .c1_i  (mem_q[1][t][cnt_q]),
      .c1l_i (lo1),
      .n0_o  (upd_n[0][t]),
      .n1_o  (upd_n[1][t])
    );
  end

  for (genvar k = 0; k < 2; k++) begin : g_cand
    horner_eval #(.M(M), .POLY(POLY)) u_eval (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (acc_clr),
      .step_i(acc_step),
      .x_i   (nxt_x_q),
      .y_i   (nxt_y_q),
      .a0_i  (upd_n[k][0]),
      .a1_i  (upd_n[k][1]),
      .disc_o(hd[k])
    );
  end

  // coefficient store: no reset, initialised by start
  always_ff @(posedge clk_i) begin
    if (state_q == ST_IDLE && start_i) begin
      for (int k = 0; k < 2; k++)
        for (int t = 0; t < 2; t++)
          for (int j = 0; j < DEPTH; j++)
            mem_q[k][t][j] <= '0;
      mem_q[0][0][0] <= M'(1);
      mem_q[1][1][0] <= M'(1);
    end else if (in_pass) begin
      for (int k = 0; k < 2; k++)
        for (int t = 0; t < 2; t++)
          mem_q[k][t][cnt_q] <= upd_n[k][t];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      span_q       <= '0;
      wdeg0_q      <= '0;
      wdeg1_q      <= '0;
      d_q          <= '0;
      have_d_q     <= 1'b0;
      eval_q       <= 1'b0;
      sel_q        <= 1'b0;
      cur_x_q      <= '0;
      nxt_x_q      <= '0;
      nxt_y_q      <= '0;
      nxt_last_q   <= 1'b0;
      disc_valid_o <= 1'b0;
      disc0_o      <= '0;
      disc1_o      <= '0;
      res_valid_o  <= 1'b0;
      res_idx_o    <= '0;
      res_c0_o     <= '0;
      res_c1_o     <= '0;
      done_o       <= 1'b0;
    end else begin
      disc_valid_o <= 1'b0;
      res_valid_o  <= 1'b0;
      done_o       <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          wdeg0_q  <= '0;
          wdeg1_q  <= WDW'(WY);
          span_q   <= (AW+1)'(1);
          have_d_q <= 1'b0;
          state_q  <= ST_WAIT;
        end
        ST_WAIT: if (pt_valid_i) begin
          nxt_x_q    <= pt_x_i;
          nxt_y_q    <= pt_y_i;
          nxt_last_q <= pt_last_i;
          cnt_q      <= span_q[AW-1:0];
          eval_q     <= 1'b1;
          state_q    <= ST_PASS;
        end
        ST_PASS: begin
          if (cnt_q == '0) state_q <= ST_FIN;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_FIN: begin
          wdeg0_q <= wdeg0_n;
          wdeg1_q <= wdeg1_n;
          span_q  <= span_n;
          if (eval_q) begin
            d_q          <= hd;
            disc0_o      <= hd[0];
            disc1_o      <= hd[1];
            disc_valid_o <= 1'b1;
            have_d_q     <= 1'b1;
            cur_x_q      <= nxt_x_q;
            if (nxt_last_q) begin
              cnt_q   <= span_n[AW-1:0];
              eval_q  <= 1'b0;     // closing update pass, nothing to evaluate
              state_q <= ST_PASS;
            end else begin
              state_q <= ST_WAIT;
            end
          end else begin
            sel_q   <= (wdeg1_n < wdeg0_n);
            cnt_q   <= AW'(span_n - 1'b1);
            state_q <= ST_OUT;
          end
        end
        ST_OUT: begin
          res_valid_o <= 1'b1;
          res_idx_o   <= cnt_q;
          res_c0_o    <= mem_q[sel_q][0][cnt_q];
          res_c1_o    <= mem_q[sel_q][1][cnt_q];
          if (cnt_q == '0) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/biv_interp_chk.sv
module biv_interp_chk
  import interp2_pkg::*;
#(
  parameter int unsigned AW       = 4,
  parameter int unsigned WDW      = 5,
  parameter int unsigned NPTS_MAX = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input state_e         state_i,
  input logic           pt_valid_i,
  input logic           pt_ready_o,
  input logic           disc_valid_o,
  input logic           res_valid_o,
  input logic [AW-1:0]  res_idx_o,
  input logic           done_o,
  input logic [WDW-1:0] wdeg0_i,
  input logic [WDW-1:0] wdeg1_i,
  input logic [AW:0]    span_i
);
  // R2
  one_point_per_iter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_valid_i && pt_ready_o) |=> !pt_ready_o);

  // R3
  disc_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_valid_o |=> !disc_valid_o);

  // R8
  done_with_idx0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (res_valid_o && res_idx_o == '0));

  // R8
  readout_contiguous_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !done_o) |=> (res_valid_o && res_idx_o == $past(res_idx_o) - 1'b1));

  // R7
  wdeg_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE && $past(state_i) != ST_IDLE) |->
      (wdeg0_i >= $past(wdeg0_i) && wdeg1_i >= $past(wdeg1_i) &&
       (wdeg0_i - $past(wdeg0_i)) + (wdeg1_i - $past(wdeg1_i)) <= WDW'(1)));

  // R10
  span_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    span_i <= (AW+1)'(NPTS_MAX + 1));
endmodule

bind biv_interp biv_interp_chk #(.AW(AW), .WDW(WDW), .NPTS_MAX(NPTS_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state_q),
  .pt_valid_i  (pt_valid_i),
  .pt_ready_o  (pt_ready_o),
  .disc_valid_o(disc_valid_o),
  .res_valid_o (res_valid_o),
  .res_idx_o   (res_idx_o),
  .done_o      (done_o),
  .wdeg0_i     (wdeg0_q),
  .wdeg1_i     (wdeg1_q),
  .span_i      (span_q)
);

// File: tb/tb_biv_interp.sv
`timescale 1ns/1ps
module tb_biv_interp;
  localparam int M = 8;
  localparam logic [7:0] POLY = 8'h1D;
  localparam int WY = 4;
  localparam int NPTS_MAX = 12;
  localparam int AW = 4;
  localparam int DEPTH = 16;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, pt_valid_i = 1'b0, pt_last_i = 1'b0;
  logic [M-1:0] pt_x_i = '0, pt_y_i = '0;
  logic pt_ready_o, disc_valid_o, res_valid_o, done_o;
  logic [M-1:0] disc0_o, disc1_o, res_c0_o, res_c1_o;
  logic [AW-1:0] res_idx_o;

  always #10 clk = ~clk;

  biv_interp #(.M(M), .POLY(POLY), .WY(WY), .NPTS_MAX(NPTS_MAX)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .pt_valid_i(pt_valid_i), .pt_ready_o(pt_ready_o),
    .pt_x_i(pt_x_i), .pt_y_i(pt_y_i), .pt_last_i(pt_last_i),
    .disc_valid_o(disc_valid_o), .disc0_o(disc0_o), .disc1_o(disc1_o),
    .res_valid_o(res_valid_o), .res_idx_o(res_idx_o),
    .res_c0_o(res_c0_o), .res_c1_o(res_c1_o), .done_o(done_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R10: GF(2^8) product, bit i = alpha^i, modulus x^8 + POLY
  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r = '0, s = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) r ^= s;
      s = s[M-1] ? ((s << 1) ^ POLY) : (s << 1);
    end
    return r;
  endfunction

  function automatic logic [M-1:0] peval(input logic [M-1:0] c [DEPTH], input logic [M-1:0] x);
    logic [M-1:0] s = '0, p = 8'd1;
    for (int j = 0; j < DEPTH; j++) begin
      s ^= gmul(c[j], p);
      p = gmul(p, x);
    end
    return s;
  endfunction

  // model state
  logic [M-1:0] q [2][2][DEPTH];
  int w [2];
  logic [M-1:0] px [NPTS_MAX], py [NPTS_MAX];
  logic [M-1:0] ed0 [NPTS_MAX], ed1 [NPTS_MAX];
  int espan [NPTS_MAX];
  int t_acc [NPTS_MAX];
  int npts, dcount, span_fin;
  logic [M-1:0] g0 [DEPTH], g1 [DEPTH];
  int got_n;
  bit done_seen;

  task automatic model(input int n);
    logic [M-1:0] o [2][2][DEPTH];
    int updates = 0, prev_nz = 0;
    for (int k = 0; k < 2; k++) for (int t = 0; t < 2; t++) for (int j = 0; j < DEPTH; j++) q[k][t][j] = '0;
    q[0][0][0] = 8'd1; q[1][1][0] = 8'd1;
    w[0] = 0; w[1] = WY;
    for (int i = 0; i < n; i++) begin
      logic [M-1:0] d [2];
      int p;
      espan[i] = 1 + updates - prev_nz;
      for (int k = 0; k < 2; k++) d[k] = peval(q[k][0], px[i]) ^ gmul(py[i], peval(q[k][1], px[i]));
      ed0[i] = d[0]; ed1[i] = d[1];
      prev_nz = (d[0] != 0 || d[1] != 0) ? 1 : 0;
      if (prev_nz == 1) begin
        updates++;
        if (d[0] != 0 && d[1] != 0) p = (w[1] < w[0]) ? 1 : 0;
        else p = (d[1] != 0) ? 1 : 0;
        o = q;
        for (int t = 0; t < 2; t++)
          for (int j = 0; j < DEPTH; j++) begin
            q[1-p][t][j] = gmul(d[p], o[1-p][t][j]) ^ gmul(d[1-p], o[p][t][j]);
            q[p][t][j] = gmul(px[i], o[p][t][j]) ^ ((j > 0) ? o[p][t][j-1] : '0);
          end
        w[p]++;
      end
    end
    span_fin = 1 + updates;
  endtask

  // monitors, sampled on the falling edge
  always @(negedge clk) begin
    if (disc_valid_o) begin
      if (dcount < npts) begin
        // R3
        check(disc0_o == ed0[dcount] && disc1_o == ed1[dcount], "R3 disc pair", {disc0_o, disc1_o}, {ed0[dcount], ed1[dcount]});
        // R4
        check(cyc - t_acc[dcount] == espan[dcount] + 2, "R4 disc timing", cyc - t_acc[dcount], espan[dcount] + 2);
        if (ed0[dcount] == 0 && ed1[dcount] == 0)
          check(disc0_o == 0 && disc1_o == 0, "R6 zero pair", {disc0_o, disc1_o}, 0);
      end else check(1'b0, "R3 extra disc", dcount, npts);
      dcount++;
    end
    if (res_valid_o) begin
      g0[res_idx_o] = res_c0_o;
      g1[res_idx_o] = res_c1_o;
      got_n++;
      if (done_o) done_seen = 1'b1;
    end
  end

  task automatic send(input int i, input bit last);
    repeat ($urandom % 3) @(negedge clk);
    while (!pt_ready_o) @(negedge clk);
    pt_valid_i = 1'b1; pt_x_i = px[i]; pt_y_i = py[i]; pt_last_i = last;
    t_acc[i] = cyc + 1;
    @(negedge clk);
    pt_valid_i = 1'b0;
    // R2
    check(!pt_ready_o, "R2 ready drop", pt_ready_o, 0);
  endtask

  task automatic run(input int n);
    int sel;
    npts = n; dcount = 0; got_n = 0; done_seen = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin g0[j] = '0; g1[j] = '0; end
    model(n);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R1
    check(pt_ready_o, "R1 ready after start", pt_ready_o, 1);
    for (int i = 0; i < n; i++) send(i, i == n - 1);
    while (!done_seen) @(negedge clk);
    sel = (w[1] < w[0]) ? 1 : 0;   // R7
    check(got_n == span_fin, "R8 coefficient count", got_n, span_fin);
    check(dcount == n, "R3 disc count", dcount, n);
    for (int j = 0; j < DEPTH; j++)
      check(g0[j] == q[sel][0][j] && g1[j] == q[sel][1][j], "R5 R7 R8 coefficient",
            {g0[j], g1[j]}, {q[sel][0][j], q[sel][1][j]});
    for (int i = 0; i < n; i++)
      check((peval(g0, px[i]) ^ gmul(py[i], peval(g1, px[i]))) == 0, "R9 vanishing",
            peval(g0, px[i]) ^ gmul(py[i], peval(g1, px[i])), 0);
  endtask

  initial begin
    void'($urandom(32'h1c0ffee));
    npts = 0;
    repeat (3) @(negedge clk);
    // R1
    check(!pt_ready_o && !disc_valid_o && !res_valid_o && !done_o, "R1 reset state",
          {pt_ready_o, disc_valid_o, res_valid_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!pt_ready_o, "R1 idle not ready", pt_ready_o, 0);

    // single point, y = 0: only candidate 0 nonzero
    px[0] = 8'h05; py[0] = 8'h00;
    run(1);

    // R6: repeated point gives a zero pair and leaves the result unchanged
    px[0] = 8'h11; py[0] = 8'h22;
    px[1] = 8'h33; py[1] = 8'h44;
    px[2] = 8'h11; py[2] = 8'h22;
    px[3] = 8'h7A; py[3] = 8'h09;
    run(4);
    check(ed0[2] == 0 && ed1[2] == 0, "R6 model zero pair", {ed0[2], ed1[2]}, 0);

    // R5: full-length runs reach the weighted-degree tie
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < NPTS_MAX; i++) begin px[i] = M'(i + 1 + 13 * r); py[i] = M'($urandom); end
      run(NPTS_MAX);
    end

    // random lengths, occasional repeats
    for (int r = 0; r < 6; r++) begin
      int n = 2 + ($urandom % (NPTS_MAX - 1));
      for (int i = 0; i < n; i++) begin
        px[i] = M'($urandom); py[i] = M'($urandom);
        if (i > 0 && ($urandom % 4) == 0) begin px[i] = px[i-1]; py[i] = py[i-1]; end
      end
      run(n);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > WDOG);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule